// File: doc/BRIEF.md
# Configurable Serial Shift Interface

This block moves one byte at a time over a synchronous three-wire serial link. Software loads a byte through a parallel write port. The unit shifts it out one bit per shift-clock cycle and at the same time collects eight incoming bits. When the eighth bit has been sampled, it raises a completion flag and a one-cycle interrupt pulse, and the received byte is available on a parallel read port. A static configuration input sets the bit order. A half-duplex option moves the outgoing data onto the bidirectional data line.

The shift clock has two possible sources, chosen at run time. The first is an internal clock divided from a free-running prescaler, which the unit then drives onto the clock pin. The second is an external clock that arrives on the clock pin. That clock is passed through a two-flop synchroniser, and its edges are detected in the system clock domain. While the unit is disabled, the clock pin carries a divided square wave from the prescaler instead.

Top module: `sshift_unit`

## Requirements
- R1: After reset: `done`=0, `irq`=0, `rd_data`=0, `sdo_o`=1, `sdio_oe`=0, and `sck_oe`=1.
- R2: While `en`=0, `sck_oe`=1 and `sck_o` is a square wave that toggles every 2^(`cfg_div_sel`+1) system clocks. A write with `en`=0 is ignored: `done` stays 0 and `rd_data` is unchanged.
- R3: A write while `en`=1 and no transfer is running starts a transfer and clears `done` at the clock edge that accepts it. A write during a running transfer is ignored.
- R4: With `cfg_lsb_first`=0, bit 7 of the written byte is sent first and the first bit received ends up in bit 7 of `rd_data`. With `cfg_lsb_first`=1, bit 0 is sent first and the first bit received ends up in bit 0.
- R5: The shift clock idles high. Output data changes only after a falling shift-clock edge, and input data is sampled on the rising edge.
- R6: With `ext_sel`=0 and `en`=1, the unit drives the clock pin (`sck_oe`=1). The clock's half period is 2^(`cfg_div_sel`+1) system clocks. Exactly eight rising edges occur per transfer, and the clock then rests high.
- R7: With `ext_sel`=1 and `en`=1, `sck_oe`=0 and the shift clock is taken from `sck_i` through a two-flop synchroniser. Input data must stay stable for at least 3 system clocks after each rising edge of `sck_i`.
- R8: The eighth sampled rising edge sets `done`=1 and raises `irq` for exactly one system clock.
- R9: With `cfg_half_duplex`=1, outgoing bits appear on `sdio_o` with `sdio_oe`=1 for the whole transfer, and `sdo_o` is held at 1. In both modes, incoming bits are read from `sdio_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lsb_first | input | 1 | Static bit order: 0 = MSB first, 1 = LSB first |
| cfg_half_duplex | input | 1 | Static: 1 = outgoing data on the bidirectional line |
| cfg_div_sel | input | SEL_W | Static prescaler tap; half period is 2^(sel+1) clocks |
| en | input | 1 | Serial function enable; 0 gives the clock pin to the divided clock |
| ext_sel | input | 1 | Shift-clock source: 0 internal, 1 external pin |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Received byte |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | One-cycle completion pulse |
| sdo_o | output | 1 | Dedicated serial data output |
| sdio_i | input | 1 | Bidirectional data line, input side |
| sdio_o | output | 1 | Bidirectional data line, output value |
| sdio_oe | output | 1 | Bidirectional data line, output enable |
| sck_i | input | 1 | Clock pin, input side |
| sck_o | output | 1 | Clock pin, output value |
| sck_oe | output | 1 | Clock pin, output enable |

## Verification
The hardest case to provoke is a write that lands while a transfer is already running. It needs an exact point in the middle of a shift sequence, and the only visible evidence is that nothing changes. The bench injects a second, inverted byte a few cycles after a transfer starts. It then confirms that exactly eight rising edges occur and that the transmitted bits and the received byte belong to the first transfer. The external-clock path is reached by toggling `sck_i` slowly from the bench, so the synchroniser delay stays inside the data hold window. Half-duplex reception is covered by looping `sdio_o` back into `sdio_i`.

// File: rtl/sshift_pkg.sv
// Shared constants and types for the serial shift interface.
package sshift_pkg;
    localparam int unsigned SS_DATA_W = 8;   // bits per transfer
    localparam int unsigned SS_SEL_W  = 4;   // prescaler tap select width
    localparam int unsigned SS_PRE_W  = 12;  // prescaler counter width

    typedef enum logic {
        CLK_INT = 1'b0,
        CLK_EXT = 1'b1
    } clk_src_e;
endpackage

// File: rtl/sshift_prescaler.sv
// Free-running prescaler. Emits a one-cycle tick every 2^(sel+1) clocks and
// a square wave that toggles on each tick.
// Assumes sel <= PRE_W-1 and that sel is changed only while idle.
module sshift_prescaler #(
    parameter int unsigned PRE_W = 12,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic             ckout
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   mask;
    logic [SEL_W:0]   shamt;

    // Tap mask: the low (sel+1) bits set.
    always_comb begin
        shamt = {1'b0, sel} + {{SEL_W{1'b0}}, 1'b1};
        mask  = ({{PRE_W{1'b0}}, 1'b1} << shamt) - {{PRE_W{1'b0}}, 1'b1};
        tick  = (({1'b0, cnt_q} & mask) == mask);
    end

    // Counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Divided square-wave output.
    always_ff @(posedge clk) begin
        if (!rst_n)    ckout <= 1'b0;
        else if (tick) ckout <= ~ckout;
    end

    // R2: the divided clock never ticks on two consecutive cycles.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sshift_edge_sync.sv
// Two-flop synchroniser for the external clock pin, plus edge detection in
// the system clock domain. The pin idles high, so all stages reset to 1.
module sshift_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    // Synchroniser chain and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Edge pulses from the synchronised level.
    always_comb begin
        rise = s2_q & ~s3_q;
        fall = ~s2_q & s3_q;
    end

    // R7: a synchronised edge is one cycle wide.
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/sshift_core.sv
// Shift engine. Loads a byte, shifts in on rising-edge pulses, updates the
// output bit on falling-edge pulses, and flags completion after DATA_W bits.
// Assumes rise and fall are never high together and lsb_first is static.
module sshift_core #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    output logic [DATA_W-1:0] shreg,
    output logic              dout,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             head;

    // Accept a write only when idle; pick the bit that goes out next.
    always_comb begin
        accept = start & ~busy;
        head   = lsb_first ? shreg[0] : shreg[DATA_W-1];
    end

    // Load, shift, count and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            irq   <= 1'b0;
            dout  <= 1'b1;
        end else begin
            irq <= 1'b0;
            if (accept) begin
                shreg <= tx_data;
                cnt_q <= '0;
                busy  <= 1'b1;
                done  <= 1'b0;
                dout  <= lsb_first ? tx_data[0] : tx_data[DATA_W-1];
            end else if (busy) begin
                if (rise) begin
                    shreg <= lsb_first ? {din, shreg[DATA_W-1:1]}
                                       : {shreg[DATA_W-2:0], din};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        irq  <= 1'b1;
                    end
                end else if (fall) begin
                    dout <= head;
                end
            end
        end
    end

    // R8: the completion pulse lasts one cycle.
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: the pulse coincides with a set done flag and an idle engine.
    a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && !busy));
    // R8: the bit count never passes the byte width.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));
    // R3: an accepted write clears done and starts the engine.
    a_r3_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !done));
endmodule

// File: rtl/sshift_unit.sv
// Top level of the serial shift interface. Builds the internal shift clock
// from the prescaler, selects internal or synchronised external edges, and
// muxes the clock and data pins.
// Assumes cfg_* inputs change only while no transfer runs, and en stays high
// for the whole of a transfer.
module sshift_unit
    import sshift_pkg::*;
#(
    parameter int unsigned DATA_W = SS_DATA_W,
    parameter int unsigned SEL_W  = SS_SEL_W,
    parameter int unsigned PRE_W  = SS_PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_lsb_first,
    input  logic              cfg_half_duplex,
    input  logic [SEL_W-1:0]  cfg_div_sel,
    input  logic              en,
    input  logic              ext_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              irq,
    output logic              sdo_o,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe
);
    clk_src_e src;
    logic     tick, ckout;
    logic     ext_rise, ext_fall;
    logic     int_rise, int_fall;
    logic     sh_rise, sh_fall;
    logic     busy, dout, sck_int;

    sshift_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_div_sel),
        .tick  (tick),
        .ckout (ckout)
    );

    sshift_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_i),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Internal shift clock: toggles on prescaler ticks during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sck_int <= 1'b1;
        else if (!busy)                    sck_int <= 1'b1;
        else if (tick && src == CLK_INT)   sck_int <= ~sck_int;
    end

    // Edge selection between internal and external sources.
    always_comb begin
        src      = clk_src_e'(ext_sel);
        int_rise = tick & busy & ~sck_int;
        int_fall = tick & busy & sck_int;
        sh_rise  = (src == CLK_EXT) ? (ext_rise & busy) : int_rise;
        sh_fall  = (src == CLK_EXT) ? (ext_fall & busy) : int_fall;
    end

    sshift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsb_first (cfg_lsb_first),
        .start     (wr_en & en),
        .tx_data   (wr_data),
        .rise      (sh_rise),
        .fall      (sh_fall),
        .din       (sdio_i),
        .shreg     (rd_data),
        .dout      (dout),
        .busy      (busy),
        .done      (done),
        .irq       (irq)
    );

    // Pin muxing for clock and data lines.
    always_comb begin
        sck_oe  = ~en | (src == CLK_INT);
        sck_o   = en ? sck_int : ckout;
        sdo_o   = cfg_half_duplex ? 1'b1 : dout;
        sdio_o  = dout;
        sdio_oe = cfg_half_duplex & busy;
    end

    // R5/R6: the internal shift clock rests high whenever no transfer runs.
    a_r6_int_clk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_int);
    // R5: internal rising and falling edges never coincide.
    a_r5_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_rise && sh_fall));
endmodule

// File: tb/sshift_unit_tb.sv
// Self-checking bench for sshift_unit: sweeps bit order, duplex mode,
// prescaler taps and clock source over several byte patterns.
module sshift_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H_EXT      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_lsb_first = 1'b0, cfg_half_duplex = 1'b0;
    logic [3:0] cfg_div_sel = 4'd0;
    logic       en = 1'b0, ext_sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       done, irq, sdo_o, sdio_o, sdio_oe, sck_o, sck_oe;
    logic       sck_i = 1'b1;
    logic       rx_bit = 1'b0;
    logic       sdio_i;

    int checks = 0, errors = 0, cycles = 0, irq_total = 0;

    // Loopback in half-duplex mode; bench data otherwise.
    assign sdio_i = sdio_oe ? sdio_o : rx_bit;

    sshift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first),
        .cfg_half_duplex(cfg_half_duplex), .cfg_div_sel(cfg_div_sel),
        .en(en), .ext_sel(ext_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .irq(irq), .sdo_o(sdo_o),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (irq) irq_total++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait (cycles > 150000);
        check(1'b0, "watchdog", cycles, 150000);
        finish_run();
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Transfer on the internal clock, monitoring the clock pin.
    task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rx,
                            input logic lsb, input logic hd,
                            input logic [3:0] sel, input bit dbl);
        int k = 0, t = 0, last = 0, irq0;
        logic prev;
        logic [7:0] exp_rd;
        @(negedge clk);
        cfg_lsb_first = lsb; cfg_half_duplex = hd; cfg_div_sel = sel;
        ext_sel = 1'b0; en = 1'b1; rx_bit = bitof(rx, 0, lsb);
        irq0 = irq_total;
        write_byte(tx);
        check(done == 1'b0, "R3 done cleared by write", done, 0);
        check(sck_oe == 1'b1, "R6 clock pin driven", sck_oe, 1);
        if (hd) check(sdio_oe == 1'b1, "R9 data line driven", sdio_oe, 1);
        prev = sck_o;
        while (!done && t < 5000) begin
            @(negedge clk); t++;
            wr_en = (dbl && t == 5);
            wr_data = ~tx;
            if (sck_o && !prev) begin
                if (k < 8) begin
                    check((hd ? sdio_o : sdo_o) == bitof(tx, k, lsb),
                          "R4/R5 tx bit", hd ? sdio_o : sdo_o, bitof(tx, k, lsb));
                    if (hd) check(sdo_o == 1'b1, "R9 sdo held high", sdo_o, 1);
                end
                if (k > 0) check((t - last) == (1 << (sel + 2)), "R6 clock period",
                                 t - last, 1 << (sel + 2));
                last = t; k++;
                if (k < 8) rx_bit = bitof(rx, k, lsb);
            end
            prev = sck_o;
        end
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        exp_rd = hd ? tx : rx;
        check(k == 8, "R6 eight rising edges", k, 8);
        check(sck_o == 1'b1, "R6 clock rests high", sck_o, 1);
        check(done == 1'b1, "R8 done set", done, 1);
        check((irq_total - irq0) == 1, "R8 single irq pulse", irq_total - irq0, 1);
        check(rd_data == exp_rd, dbl ? "R3 busy write ignored" : "R4 rx byte",
              rd_data, exp_rd);
    endtask

    // Transfer on an external clock driven by the bench.
    task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rx,
                            input logic lsb, input logic hd);
        int irq0;
        logic [7:0] exp_rd;
        @(negedge clk);
        cfg_lsb_first = lsb; cfg_half_duplex = hd; ext_sel = 1'b1; en = 1'b1;
        sck_i = 1'b1;
        irq0 = irq_total;
        @(negedge clk);
        check(sck_oe == 1'b0, "R7 clock pin released", sck_oe, 0);
        write_byte(tx);
        check(done == 1'b0, "R3 done cleared by write", done, 0);
        for (int i = 0; i < 8; i++) begin
            rx_bit = bitof(rx, i, lsb);
            sck_i = 1'b0;
            repeat (H_EXT) @(negedge clk);
            check((hd ? sdio_o : sdo_o) == bitof(tx, i, lsb), "R7/R5 ext tx bit",
                  hd ? sdio_o : sdo_o, bitof(tx, i, lsb));
            sck_i = 1'b1;
            repeat (H_EXT) @(negedge clk);
        end
        exp_rd = hd ? tx : rx;
        check(done == 1'b1, "R8 done set ext", done, 1);
        check((irq_total - irq0) == 1, "R8 single irq ext", irq_total - irq0, 1);
        check(rd_data == exp_rd, "R7 ext rx byte", rd_data, exp_rd);
        ext_sel = 1'b0;
    endtask

    // Measure divided clock toggle spacing while disabled.
    task automatic ckout_period(input logic [3:0] sel);
        int t = 0, first = -1, second = -1;
        logic prev;
        @(negedge clk); en = 1'b0; cfg_div_sel = sel;
        repeat (2) @(negedge clk);
        prev = sck_o;
        while (second < 0 && t < 1000) begin
            @(negedge clk); t++;
            if (sck_o != prev) begin
                if (first < 0) first = t; else second = t;
            end
            prev = sck_o;
        end
        check(sck_oe == 1'b1, "R2 clock pin driven when disabled", sck_oe, 1);
        check((second - first) == (1 << (sel + 1)), "R2 divided clock half period",
              second - first, 1 << (sel + 1));
    endtask

    initial begin
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && irq == 1'b0, "R1 flags after reset", {done, irq}, 0);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        check(sdo_o == 1'b1 && sdio_oe == 1'b0, "R1 data pins after reset",
              {sdo_o, sdio_oe}, 2'b10);
        check(sck_oe == 1'b1, "R1 clock pin after reset", sck_oe, 1);

        // R2: write while disabled is ignored.
        write_byte(8'hA5);
        repeat (20) @(negedge clk);
        check(done == 1'b0, "R2 disabled write no done", done, 0);
        check(rd_data == 8'h00, "R2 disabled write no load", rd_data, 0);
        check(sdio_oe == 1'b0, "R2 disabled write no drive", sdio_oe, 0);

        ckout_period(4'd0);
        ckout_period(4'd1);
        ckout_period(4'd3);

        for (int lsb = 0; lsb < 2; lsb++)
            for (int hd = 0; hd < 2; hd++)
                for (int p = 0; p < 5; p++)
                    xfer_int(pats[p], pats[p] ^ 8'h5A ^ 8'(p * 17),
                             lsb[0], hd[0], 4'(p % 3), 1'b0);

        // R3: second write in mid-transfer must be ignored.
        xfer_int(8'hC3, 8'h96, 1'b0, 1'b0, 4'd2, 1'b1);
        xfer_int(8'h1E, 8'h4B, 1'b1, 1'b0, 4'd1, 1'b1);

        for (int lsb = 0; lsb < 2; lsb++)
            for (int hd = 0; hd < 2; hd++) begin
                xfer_ext(8'hB4, 8'h2D, lsb[0], hd[0]);
                xfer_ext(8'h71, 8'hE8, lsb[0], hd[0]);
            end

        finish_run();
    end
endmodule